// File: doc/BRIEF.md
# SDRAM Burst Data Path Sequencer

This block drives the data side of column bursts on a single-data-rate SDRAM bus. A memory controller presents a read or write column command together with the mode currently programmed into the memory (beat count, address ordering, CAS latency and the single-beat write option). The sequencer then produces the column address of every beat, one per clock, starting on the command clock. It also tells the controller when read data arrives and which byte lanes the memory drives, and it gives the per-byte write enables for write beats.

The data bus is 72 bits wide and split into eight 9-bit lanes, each with its own mask input. Masks act on the same clock for writes and two clocks later for reads. A precharge cuts a read burst short, and so does any new column command, which the block accepts on every clock. Row opening, refresh, bank timing, pads and check-bit generation are handled elsewhere.

Top module: `sdr_burst_seq`

## Requirements
- R1: `cfg_burst_len` selects the beat count: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Beats run one per clock and the first beat, at the commanded column, is issued on the command clock.
- R2: With `cfg_interleave` low, the beat column is the start column plus the beat index, wrapping inside the block of burst-length columns aligned to that length (start 6 with 4 beats gives 6, 7, 4, 5).
- R3: With `cfg_interleave` high, the beat column is the start column XOR the beat index (start 5 with 8 beats gives 5, 4, 7, 6, 1, 0, 3, 2).
- R4: Every read beat raises `rd_capture` exactly CAS-latency clocks later with `rd_cap_col` equal to that beat's column; `cfg_cas_lat` value 3 means 3 clocks and any other value means 2.
- R5: On a write beat `wr_lane_en[i]` is the inverse of `dqm_in[i]` in that same clock; in any other clock `wr_lane_en` is zero.
- R6: When `rd_capture` is high, `rd_lane_oe[i]` is the inverse of `dqm_in[i]` sampled two clocks earlier; when `rd_capture` is low, `rd_lane_oe` is zero.
- R7: With `cfg_single_write` high, a write command transfers exactly one beat while a read still uses the programmed beat count.
- R8: `pre_stop` high in a clock without a command ends the running burst: no beat is issued from that clock on, so read captures end CAS-latency clocks after the precharge.
- R9: A column command is accepted in any clock; it issues its own first beat in that clock and ends any burst still in progress.
- R10: While `rst_n` is low (sampled at a clock edge) all outputs are zero and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Column command present this clock |
| cmd_write | input | 1 | Command direction, 1 for write |
| cmd_col | input | COL_W | Start column of the burst |
| cfg_burst_len | input | 2 | Beat count code (0:1, 1:2, 2:4, 3:8) |
| cfg_interleave | input | 1 | 1 selects XOR ordering, 0 wrapping ordering |
| cfg_cas_lat | input | 2 | CAS latency, 3 or 2 |
| cfg_single_write | input | 1 | Writes transfer one beat only |
| pre_stop | input | 1 | Precharge issued, ends the running burst |
| dqm_in | input | LANES | Byte-lane masks, 1 masks the lane |
| beat_valid | output | 1 | A burst beat occupies this clock |
| beat_write | output | 1 | Direction of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| wr_lane_en | output | LANES | Lanes written in this clock |
| rd_capture | output | 1 | Read data is on the bus this clock |
| rd_cap_col | output | COL_W | Column of the read data on the bus |
| rd_lane_oe | output | LANES | Lanes the memory drives this clock |

## Verification
Beat columns and write lane enables are due in the very clock the command or the preceding beat occupies, so the bench stamps each expected beat with the command cycle plus its index. Read captures are due that stamp plus the CAS latency, and their lane enables use the mask recorded two cycles before the capture. A driver task pushes these cycle-stamped items into queues, and a monitor on the falling edge pops and compares them, so an early, late, missing or extra beat or capture is flagged in the cycle it occurs. Truncated bursts push only the beats that must appear, so any beat that survives a precharge or a following command is reported as unexpected.

// File: rtl/sdr_seq_pkg.sv
// Package: shared constants, types and helpers of the burst sequencer.
// Assumes: burst codes 0..3 stand for 1, 2, 4 and 8 beats.
package sdr_seq_pkg;

    localparam int MAX_BEATS   = 8;
    localparam int CNT_W       = $clog2(MAX_BEATS);
    localparam int LEN_W       = CNT_W + 1;
    localparam int CL_SHORT    = 2;
    localparam int CL_LONG     = 3;
    localparam int DQM_RD_LAT  = 2;

    typedef logic [1:0]       bl_code_t;
    typedef logic [LEN_W-1:0] beat_len_t;

    // Beat count of a burst code.
    function automatic beat_len_t beats_of(input bl_code_t code);
        return beat_len_t'(1) << code;
    endfunction

endpackage

// File: rtl/sdr_col_gen.sv
// Module: column generator. Issues one beat per clock for a column
// command, the first one combinationally on the command clock, and walks
// the burst in wrapping or XOR order. Mode settings are latched with the
// command. Assumes cmd_valid is already qualified by reset.
module sdr_col_gen
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ok,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  bl_code_t         cfg_burst_len,
    input  logic             cfg_interleave,
    input  logic             cfg_single_write,
    input  logic             pre_stop,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_col
);

    logic             run_q;
    logic             wr_q;
    logic             il_q;
    logic [CNT_W-1:0] cnt_q;
    beat_len_t        len_q;
    logic [COL_W-1:0] base_q;
    beat_len_t        len_now;
    logic [COL_W-1:0] mask_q;

    // Column of beat idx inside a burst of the given alignment mask.
    function automatic logic [COL_W-1:0] order_col(
        input logic [COL_W-1:0] base,
        input logic [CNT_W-1:0] idx,
        input logic [COL_W-1:0] mask,
        input logic             xor_order
    );
        if (xor_order)
            return base ^ COL_W'(idx);
        return (base & ~mask) | ((base + COL_W'(idx)) & mask);
    endfunction

    // Beat count for the command in this clock, single-beat writes applied.
    always_comb begin
        len_now = (cmd_write && cfg_single_write) ? beat_len_t'(1) : beats_of(cfg_burst_len);
    end

    // Alignment mask of the burst in flight.
    always_comb begin
        mask_q = COL_W'(len_q - beat_len_t'(1));
    end

    // Current beat: a new command wins, else the running burst unless stopped.
    always_comb begin
        beat_valid = 1'b0;
        beat_write = 1'b0;
        beat_col   = '0;
        if (cmd_ok) begin
            beat_valid = 1'b1;
            beat_write = cmd_write;
            beat_col   = cmd_col;
        end else if (run_q && !pre_stop) begin
            beat_valid = 1'b1;
            beat_write = wr_q;
            beat_col   = order_col(base_q, cnt_q, mask_q, il_q);
        end
    end

    // Burst state: load on a command, step per beat, clear at end or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wr_q   <= 1'b0;
            il_q   <= 1'b0;
            cnt_q  <= '0;
            len_q  <= beat_len_t'(1);
            base_q <= '0;
        end else if (cmd_ok) begin
            run_q  <= (len_now > beat_len_t'(1));
            wr_q   <= cmd_write;
            il_q   <= cfg_interleave;
            cnt_q  <= CNT_W'(1);
            len_q  <= len_now;
            base_q <= cmd_col;
        end else if (run_q) begin
            if (pre_stop) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (beat_len_t'(cnt_q) == len_q - beat_len_t'(1))
                    run_q <= 1'b0;
            end
        end
    end

    AST_BEAT_INDEX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (beat_len_t'(cnt_q) < len_q)); // R1

    AST_BEAT_STAYS_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !cmd_ok) |-> (((beat_col ^ base_q) & ~mask_q) == '0)); // R2

    AST_SINGLE_WRITE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_write && cfg_single_write) |=> (!beat_valid || cmd_ok)); // R7

    AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stop && !cmd_ok) |=> (!beat_valid || cmd_ok)); // R8

endmodule

// File: rtl/sdr_rd_pipe.sv
// Module: read return pipe. Delays read beats and their columns by the
// CAS latency and the byte masks by the fixed read-mask latency, then
// forms the capture strobe and the per-lane drive enables.
// Assumes cfg_cas_lat only changes while no read beat is in flight.
module sdr_rd_pipe
    import sdr_seq_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int LANES  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_rd,
    input  logic [COL_W-1:0] beat_col,
    input  logic [1:0]       cfg_cas_lat,
    input  logic [LANES-1:0] dqm_in,
    output logic             rd_capture,
    output logic [COL_W-1:0] rd_cap_col,
    output logic [LANES-1:0] rd_lane_oe
);

    logic             vld_sr [1:MAX_CL];
    logic [COL_W-1:0] col_sr [1:MAX_CL];
    logic [LANES-1:0] dqm_sr [1:DQM_RD_LAT];
    int               cl_idx;

    // Shift read beats, their columns and the lane masks one clock per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 1; k <= MAX_CL; k++) begin
                vld_sr[k] <= 1'b0;
                col_sr[k] <= '0;
            end
            for (int k = 1; k <= DQM_RD_LAT; k++)
                dqm_sr[k] <= '0;
        end else begin
            vld_sr[1] <= beat_rd;
            col_sr[1] <= beat_col;
            for (int k = 2; k <= MAX_CL; k++) begin
                vld_sr[k] <= vld_sr[k-1];
                col_sr[k] <= col_sr[k-1];
            end
            dqm_sr[1] <= dqm_in;
            for (int k = 2; k <= DQM_RD_LAT; k++)
                dqm_sr[k] <= dqm_sr[k-1];
        end
    end

    // Tap chosen by the programmed latency.
    always_comb begin
        cl_idx     = (cfg_cas_lat == 2'(CL_LONG)) ? CL_LONG : CL_SHORT;
        rd_capture = vld_sr[cl_idx];
        rd_cap_col = col_sr[cl_idx];
    end

    // Per-lane drive enable: data on the bus and lane not masked.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
        assign rd_lane_oe[g] = rd_capture & ~dqm_sr[DQM_RD_LAT][g];
    end

    AST_CAPTURE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |-> ((cfg_cas_lat == 2'(CL_LONG)) ? $past(beat_rd, 3) : $past(beat_rd, 2))); // R4

    AST_LANES_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lane_oe != '0) |-> rd_capture); // R6

endmodule

// File: rtl/sdr_burst_seq.sv
// Module: top of the burst data path sequencer. Qualifies commands with
// reset, generates beat columns, forms same-clock write lane enables and
// feeds read beats into the latency pipe.
// Assumes one controller drives commands and precharge stops.
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int LANES  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       cfg_burst_len,
    input  logic             cfg_interleave,
    input  logic [1:0]       cfg_cas_lat,
    input  logic             cfg_single_write,
    input  logic             pre_stop,
    input  logic [LANES-1:0] dqm_in,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_col,
    output logic [LANES-1:0] wr_lane_en,
    output logic             rd_capture,
    output logic [COL_W-1:0] rd_cap_col,
    output logic [LANES-1:0] rd_lane_oe
);

    logic cmd_ok;
    logic beat_rd;

    // Commands count only outside reset.
    assign cmd_ok  = cmd_valid & rst_n;
    // Read beats feed the return pipe.
    assign beat_rd = beat_valid & ~beat_write;

    sdr_col_gen #(
        .COL_W (COL_W)
    ) u_col_gen (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_ok           (cmd_ok),
        .cmd_write        (cmd_write),
        .cmd_col          (cmd_col),
        .cfg_burst_len    (cfg_burst_len),
        .cfg_interleave   (cfg_interleave),
        .cfg_single_write (cfg_single_write),
        .pre_stop         (pre_stop),
        .beat_valid       (beat_valid),
        .beat_write       (beat_write),
        .beat_col         (beat_col)
    );

    sdr_rd_pipe #(
        .COL_W  (COL_W),
        .LANES  (LANES),
        .MAX_CL (MAX_CL)
    ) u_rd_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_rd     (beat_rd),
        .beat_col    (beat_col),
        .cfg_cas_lat (cfg_cas_lat),
        .dqm_in      (dqm_in),
        .rd_capture  (rd_capture),
        .rd_cap_col  (rd_cap_col),
        .rd_lane_oe  (rd_lane_oe)
    );

    // Per-lane write enable in the beat's own clock.
    for (genvar g = 0; g < LANES; g++) begin : g_wr_lane
        assign wr_lane_en[g] = beat_valid & beat_write & ~dqm_in[g];
    end

    AST_NEW_CMD_OWNS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (beat_valid && beat_write == cmd_write && beat_col == cmd_col)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (!rd_capture && rd_lane_oe == '0)); // R10

endmodule

// File: tb/sdr_burst_seq_test.sv
// Scoreboard bench: driver tasks queue cycle-stamped beats and captures,
// a falling-edge monitor pops and compares them.
module sdr_burst_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_write;
    logic [11:0] cmd_col;
    logic [1:0]  cfg_burst_len, cfg_cas_lat;
    logic        cfg_interleave, cfg_single_write, pre_stop;
    logic [7:0]  dqm_in = 8'h00;
    logic        beat_valid, beat_write, rd_capture;
    logic [11:0] beat_col, rd_cap_col;
    logic [7:0]  wr_lane_en, rd_lane_oe;

    always #2 clk = ~clk;

    sdr_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_cas_lat(cfg_cas_lat), .cfg_single_write(cfg_single_write), .pre_stop(pre_stop),
        .dqm_in(dqm_in), .beat_valid(beat_valid), .beat_write(beat_write), .beat_col(beat_col),
        .wr_lane_en(wr_lane_en), .rd_capture(rd_capture), .rd_cap_col(rd_cap_col),
        .rd_lane_oe(rd_lane_oe)
    );

    typedef struct {
        int          cyc;
        logic [11:0] col;
        logic        wr;
        string       req;
    } item_t;

    item_t      beat_q[$];
    item_t      cap_q[$];
    item_t      it;
    logic [7:0] dqm_hist [256];
    logic [7:0] exp_l;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    int         bl_cfg, cl_cfg;
    bit         il_cfg, sw_cfg, mask_on = 0, started = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Mask pattern per cycle, recorded for the read-lane model.
    always @(posedge clk) begin
        #1;
        dqm_in = mask_on ? (8'(cyc * 37) ^ 8'hA4) : 8'h00;
        dqm_hist[cyc & 255] = dqm_in;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic setcfg(input int bl, input bit il, input int cl, input bit sw);
        bl_cfg = bl; il_cfg = il; cl_cfg = cl; sw_cfg = sw;
        cfg_burst_len = 2'(bl); cfg_interleave = il; cfg_cas_lat = 2'(cl); cfg_single_write = sw;
    endtask

    // Driver: issue one command, queue the beats that must appear.
    task automatic issue(input logic [11:0] col, input bit wr, input int keep, input string tag);
        int len, n, off;
        logic [11:0] c;
        len = (wr && sw_cfg) ? 1 : (1 << bl_cfg);
        n   = (keep < len) ? keep : len;
        for (int i = 0; i < n; i++) begin
            if (il_cfg) c = col ^ 12'(i);
            else begin
                off = int'(col) % len;
                c   = col - 12'(off) + 12'((off + i) % len);
            end
            beat_q.push_back('{cyc + i, c, wr, tag});
            if (!wr) cap_q.push_back('{cyc + i + cl_cfg, c, 1'b0, (tag == "R8") ? "R8" : "R4"});
        end
        cmd_valid = 1'b1; cmd_write = wr; cmd_col = col;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic precharge();
        pre_stop = 1'b1;
        tick();
        pre_stop = 1'b0;
    endtask

    // Monitor: compare beats and captures against the queues.
    always @(negedge clk) begin
        if (started && !done) begin
            while (beat_q.size() > 0 && beat_q[0].cyc < cyc) begin
                chk(0, beat_q[0].req, "missing beat", 0, int'(beat_q[0].col));
                void'(beat_q.pop_front());
            end
            if (beat_valid) begin
                if (beat_q.size() == 0 || beat_q[0].cyc != cyc)
                    chk(0, "R9", "unexpected beat", int'(beat_col), 0);
                else begin
                    it = beat_q.pop_front();
                    chk(beat_col == it.col, it.req, "beat column", int'(beat_col), int'(it.col));
                    chk(beat_write == it.wr, it.req, "beat direction", int'(beat_write), int'(it.wr));
                    if (it.wr) begin
                        exp_l = ~dqm_in;
                        chk(wr_lane_en == exp_l, "R5", "write lanes", int'(wr_lane_en), int'(exp_l));
                    end
                end
            end else if (beat_q.size() > 0 && beat_q[0].cyc == cyc) begin
                chk(0, beat_q[0].req, "missing beat", 0, int'(beat_q[0].col));
                void'(beat_q.pop_front());
            end
            if (!(beat_valid && beat_write))
                chk(wr_lane_en == 8'h00, "R5", "write lanes outside write", int'(wr_lane_en), 0);

            while (cap_q.size() > 0 && cap_q[0].cyc < cyc) begin
                chk(0, cap_q[0].req, "missing capture", 0, int'(cap_q[0].col));
                void'(cap_q.pop_front());
            end
            if (rd_capture) begin
                if (cap_q.size() == 0 || cap_q[0].cyc != cyc)
                    chk(0, "R8", "unexpected capture", int'(rd_cap_col), 0);
                else begin
                    it = cap_q.pop_front();
                    chk(rd_cap_col == it.col, it.req, "capture column", int'(rd_cap_col), int'(it.col));
                    exp_l = ~dqm_hist[(cyc - 2) & 255];
                    chk(rd_lane_oe == exp_l, "R6", "read lanes", int'(rd_lane_oe), int'(exp_l));
                end
            end else begin
                if (cap_q.size() > 0 && cap_q[0].cyc == cyc) begin
                    chk(0, cap_q[0].req, "missing capture", 0, int'(cap_q[0].col));
                    void'(cap_q.pop_front());
                end
                chk(rd_lane_oe == 8'h00, "R6", "read lanes without capture", int'(rd_lane_oe), 0);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) dqm_hist[i] = 8'h00;
        rst_n = 1'b0; pre_stop = 1'b0;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 12'h123;   // ignored in reset (R10)
        setcfg(2, 0, 3, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(beat_valid == 1'b0, "R10", "beat in reset", int'(beat_valid), 0);
        chk(rd_capture == 1'b0, "R10", "capture in reset", int'(rd_capture), 0);
        chk(wr_lane_en == 8'h00, "R10", "write lanes in reset", int'(wr_lane_en), 0);
        chk(rd_lane_oe == 8'h00, "R10", "read lanes in reset", int'(rd_lane_oe), 0);
        tick();
        cmd_valid = 1'b0; rst_n = 1'b1; started = 1;
        idle(2);

        // R2: wrapping order, 4 beats, CL3.
        issue(12'h006, 0, 8, "R2");
        idle(12);
        // R3: XOR order, 8 beats, CL2, with lane masks.
        mask_on = 1;
        setcfg(3, 1, 2, 0);
        issue(12'h005, 0, 8, "R3");
        idle(12);
        // R5: 8-beat write, wrapping order, masks in the same clock.
        setcfg(3, 0, 2, 0);
        issue(12'h013, 1, 8, "R5");
        idle(12);
        // R7: single-beat writes, reads keep 4 beats.
        setcfg(2, 0, 3, 1);
        issue(12'h040, 1, 8, "R7");
        idle(3);
        issue(12'h042, 0, 8, "R7");
        idle(12);
        // R1: 1-beat and 2-beat bursts.
        setcfg(0, 0, 3, 0);
        issue(12'h007, 0, 8, "R1");
        idle(6);
        setcfg(1, 1, 3, 0);
        issue(12'h009, 0, 8, "R1");
        idle(8);
        // R8: precharge after two beats, CL3 then CL2.
        setcfg(3, 0, 3, 0);
        issue(12'h020, 0, 2, "R8");
        idle(1);
        precharge();
        idle(12);
        setcfg(3, 0, 2, 0);
        issue(12'h028, 0, 2, "R8");
        idle(1);
        precharge();
        idle(12);
        // R9: commands cut running bursts, one per clock.
        setcfg(3, 0, 3, 0);
        issue(12'h030, 0, 3, "R9");
        idle(2);
        issue(12'h050, 1, 8, "R9");
        idle(12);
        setcfg(2, 0, 2, 0);
        issue(12'h061, 0, 1, "R9");
        issue(12'h062, 0, 1, "R9");
        issue(12'h063, 0, 4, "R9");
        idle(12);

        @(negedge clk);
        done = 1;
        chk(beat_q.size() == 0, "R1", "beats left over", beat_q.size(), 0);
        chk(cap_q.size() == 0, "R4", "captures left over", cap_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule